// File: doc/BRIEF.md
# Calendar Shadow Register Read Interface

This block sits between a free-running calendar counter, which runs on its own slow clock, and a bus-side register read port. It keeps bus-domain copies of the sub-second, time-of-day and date values. Every fixed number of calendar-clock periods the counter side captures all three live values together and hands them across with a toggle handshake. The bus side then reloads its copies from the captured set, so no multi-bit value is ever sampled while it is changing.

Software reads the sub-second or time register first. That read freezes the copies. The date read releases them, so the three values always belong to the same instant. A refresh that arrives while the copies are frozen is held back and applied in the cycle after release. A sync flag shows when the copies were last reloaded. Software clears it with a write, and taking the freeze also clears it. Software waits for the flag to rise again before it re-reads in quick succession. When the bypass input is high, reads return the live counter values directly. No freeze applies in that mode.

The sub-second field counts down and reloads from the synchronous prescaler value, so the fraction of a second is (reload - sub) / (reload + 1). After a shift operation the sub-second value can exceed the reload value. In that case the true time is one second less than the time and date show. The block passes all values through unchanged; software applies this correction.

Top module: `cal_shadow_rd`

## Requirements
- R1: After reset all three copies read as zero, the sync flag is low and no freeze is held.
- R2: While not frozen, the copies are reloaded from one simultaneous capture of the live values, taken every SYNC_DIV calendar-clock periods. A sub-second, time, date read sequence always returns values from a single instant, never older than the previous capture.
- R3: The sync flag goes high in the cycle in which the copies are reloaded.
- R4: A read with `rd_sel` = 0 (sub-second) or `rd_sel` = 1 (time) takes the freeze. While it is held, none of the three copies changes, however many captures arrive.
- R5: A read with `rd_sel` = 2 (date) releases the freeze. A capture missed during the freeze reloads the copies one cycle after release, and later captures keep reloading them.
- R6: Taking the freeze clears the sync flag, and the flag stays low until the first reload after release.
- R7: A one-cycle high pulse on `flag_clr` clears the sync flag. If a reload falls in the same cycle, the flag is set instead.
- R8: With `bypass` high, `rd_data` shows the live input selected by `rd_sel`. Reads in this mode neither take nor release the freeze and do not clear the flag.
- R9: `rd_sel` = 3 returns zero and a read with it has no effect on the freeze or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous active-low reset |
| cal_clk | input | 1 | Slow calendar clock |
| cal_rst_n | input | 1 | Calendar-domain synchronous active-low reset |
| live_ss | input | SS_W | Live sub-second down-count (calendar domain) |
| live_tm | input | TM_W | Live time-of-day value (calendar domain) |
| live_dt | input | DT_W | Live date value (calendar domain) |
| rd_en | input | 1 | One-cycle read strobe |
| rd_sel | input | 2 | 0 sub-second, 1 time, 2 date, 3 unused |
| rd_data | output | RD_W | Selected value, zero-extended, combinational |
| bypass | input | 1 | High: reads show the live values |
| flag_clr | input | 1 | Write-zero pulse that clears the sync flag |
| sync_flag | output | 1 | High once the copies have been reloaded |

## Verification
A freeze that is lost or released too early shows as a time value that does not match the sub-second or date read a few cycles before it. A freeze that is never released shows as a sync flag that stays low, and as time values that fall further behind the live count on every later read. A dropped deferred reload or a broken handshake shows within one capture period as stale or mismatched values. Flag faults show in the cycle after the clear write or the freeze read.

// File: rtl/cal_shadow_pkg.sv
// Shared constants for the calendar shadow read interface.
// Assumes a 2-bit register select on the read port.
package cal_shadow_pkg;
    localparam logic [1:0] SEL_SUBSEC = 2'd0;
    localparam logic [1:0] SEL_TIME   = 2'd1;
    localparam logic [1:0] SEL_DATE   = 2'd2;
    localparam logic [1:0] SEL_NONE   = 2'd3;
endpackage

// File: rtl/cal_shadow_xfer.sv
// Captures the live calendar values every SYNC_DIV calendar cycles and
// signals each capture to the bus domain through a toggle synchronizer.
// Assumes clk runs at least four times faster than cal_clk, so the held
// capture is stable for the whole time the bus side needs to take it.
module cal_shadow_xfer #(
    parameter int SS_W        = 16,
    parameter int TM_W        = 24,
    parameter int DT_W        = 24,
    parameter int SYNC_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            cal_clk,
    input  logic            cal_rst_n,
    input  logic [SS_W-1:0] live_ss,
    input  logic [TM_W-1:0] live_tm,
    input  logic [DT_W-1:0] live_dt,
    input  logic            clk,
    input  logic            rst_n,
    output logic [SS_W-1:0] hold_ss,
    output logic [TM_W-1:0] hold_tm,
    output logic [DT_W-1:0] hold_dt,
    output logic            xfer_evt
);
    localparam int DIV_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;

    logic [DIV_W-1:0]     div_q;
    logic                 tog_q;
    logic [SYNC_STAGES:0] sync_q;

    // Calendar side: count the cadence, capture all three values together, flip the toggle.
    always_ff @(posedge cal_clk) begin
        if (!cal_rst_n) begin
            div_q   <= '0;
            tog_q   <= 1'b0;
            hold_ss <= '0;
            hold_tm <= '0;
            hold_dt <= '0;
        end else if (div_q == DIV_W'(SYNC_DIV - 1)) begin
            div_q   <= '0;
            tog_q   <= ~tog_q;
            hold_ss <= live_ss;
            hold_tm <= live_tm;
            hold_dt <= live_dt;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Bus side: synchronize the toggle and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
    end

    assign xfer_evt = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    // R2: the held capture only moves together with the toggle.
    p_hold_with_toggle_r2: assert property (@(posedge cal_clk) disable iff (!cal_rst_n)
        $stable(tog_q) |-> ($stable(hold_ss) && $stable(hold_tm) && $stable(hold_dt)));

    // R2: each capture is announced by a single one-cycle event.
    p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_evt |=> !xfer_evt);
endmodule

// File: rtl/cal_shadow_lock.sv
// Freeze, deferred-refresh and sync-flag control for the shadow copies.
// Assumes at most one read strobe per cycle and a single select value.
module cal_shadow_lock
    import cal_shadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic [1:0] rd_sel,
    input  logic       bypass,
    input  logic       flag_clr,
    input  logic       xfer_evt,
    output logic       load,
    output logic       locked,
    output logic       sync_flag
);
    logic lock_q, pend_q, flag_q;
    logic lock_take, lock_rel, due;

    // Decode reads that freeze or release, and decide whether a reload happens now.
    always_comb begin
        lock_take = rd_en && !bypass && (rd_sel == SEL_SUBSEC || rd_sel == SEL_TIME);
        lock_rel  = rd_en && !bypass && (rd_sel == SEL_DATE);
        due       = xfer_evt || pend_q;
        load      = due && !lock_q && !lock_take;
    end

    // Freeze state: set by a low-order read, cleared by the date read.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_q <= 1'b0;
        else if (lock_take) lock_q <= 1'b1;
        else if (lock_rel)  lock_q <= 1'b0;
    end

    // Remember a capture that arrived while reloads were blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= due && !load;
    end

    // Sync flag: a reload sets it, a freeze or a clear write drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (load)                  flag_q <= 1'b1;
        else if (lock_take || flag_clr) flag_q <= 1'b0;
    end

    assign locked    = lock_q;
    assign sync_flag = flag_q;

    // R5: a date read while frozen releases the freeze.
    p_date_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bypass && rd_sel == SEL_DATE) |=> !lock_q);

    // R6: taking the freeze leaves the flag low.
    p_freeze_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bypass && (rd_sel == SEL_SUBSEC || rd_sel == SEL_TIME)) |=> !flag_q);

    // R8: bypass reads leave the freeze untouched.
    p_bypass_no_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bypass) |=> (lock_q == $past(lock_q)));

    // R5: a deferred reload is not held past release.
    p_pending_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !lock_q && !rd_en) |=> !pend_q);
endmodule

// File: rtl/cal_shadow_rd.sv
// Top of the calendar shadow read interface: shadow copies, read mux, bypass.
// Assumes clk is at least four times faster than cal_clk; live_* are
// stable between cal_clk edges.
module cal_shadow_rd
    import cal_shadow_pkg::*;
#(
    parameter int SS_W     = 16,
    parameter int TM_W     = 24,
    parameter int DT_W     = 24,
    parameter int SYNC_DIV = 2,
    localparam int RD_W    = (SS_W > TM_W) ? ((SS_W > DT_W) ? SS_W : DT_W)
                                           : ((TM_W > DT_W) ? TM_W : DT_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cal_clk,
    input  logic            cal_rst_n,
    input  logic [SS_W-1:0] live_ss,
    input  logic [TM_W-1:0] live_tm,
    input  logic [DT_W-1:0] live_dt,
    input  logic            rd_en,
    input  logic [1:0]      rd_sel,
    output logic [RD_W-1:0] rd_data,
    input  logic            bypass,
    input  logic            flag_clr,
    output logic            sync_flag
);
    logic [SS_W-1:0] hold_ss, sh_ss;
    logic [TM_W-1:0] hold_tm, sh_tm;
    logic [DT_W-1:0] hold_dt, sh_dt;
    logic            xfer_evt, load, locked;

    cal_shadow_xfer #(
        .SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W),
        .SYNC_DIV(SYNC_DIV), .SYNC_STAGES(2)
    ) xfer_i (
        .cal_clk(cal_clk), .cal_rst_n(cal_rst_n),
        .live_ss(live_ss), .live_tm(live_tm), .live_dt(live_dt),
        .clk(clk), .rst_n(rst_n),
        .hold_ss(hold_ss), .hold_tm(hold_tm), .hold_dt(hold_dt),
        .xfer_evt(xfer_evt)
    );

    cal_shadow_lock lock_i (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_sel(rd_sel), .bypass(bypass),
        .flag_clr(flag_clr), .xfer_evt(xfer_evt),
        .load(load), .locked(locked), .sync_flag(sync_flag)
    );

    // Shadow copies: reload all three from the synchronized capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ss <= '0;
            sh_tm <= '0;
            sh_dt <= '0;
        end else if (load) begin
            sh_ss <= hold_ss;
            sh_tm <= hold_tm;
            sh_dt <= hold_dt;
        end
    end

    // Read mux: the shadow copy, or the live value in bypass mode.
    always_comb begin
        case (rd_sel)
            SEL_SUBSEC: rd_data = bypass ? RD_W'(live_ss) : RD_W'(sh_ss);
            SEL_TIME:   rd_data = bypass ? RD_W'(live_tm) : RD_W'(sh_tm);
            SEL_DATE:   rd_data = bypass ? RD_W'(live_dt) : RD_W'(sh_dt);
            default:    rd_data = '0;
        endcase
    end

    // R4: nothing in the shadow set moves while the freeze is held.
    p_frozen_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(sh_ss) && $stable(sh_tm) && $stable(sh_dt)));

    // R3: any change of the shadow set comes with the flag high.
    p_change_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_tm) |-> sync_flag);
endmodule

// File: tb/cal_shadow_rd_tb_top.sv
// Bench: the live values come from one count n, so that sub = 3 - n%4,
// time = n and date = n/4. A read set is coherent when it fits one n.
module cal_shadow_rd_tb_top;
    localparam int SS_W = 16, TM_W = 24, DT_W = 24, RD_W = 24;

    logic clk = 1'b0, cal_clk = 1'b0;
    logic rst_n = 1'b0, cal_rst_n = 1'b0;
    logic rd_en = 1'b0, bypass = 1'b0, flag_clr = 1'b0;
    logic [1:0] rd_sel = 2'd3;
    logic [RD_W-1:0] rd_data;
    logic sync_flag;
    logic [31:0] n;
    logic [SS_W-1:0] live_ss;
    logic [TM_W-1:0] live_tm;
    logic [DT_W-1:0] live_dt;

    int tests = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;
    initial begin
        #3;
        forever #32 cal_clk = ~cal_clk;
    end

    always @(posedge cal_clk) begin
        if (!cal_rst_n) n <= 0;
        else            n <= n + 1;
    end
    assign live_ss = SS_W'(3 - (n % 4));
    assign live_tm = TM_W'(n);
    assign live_dt = DT_W'(n / 4);

    cal_shadow_rd #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W), .SYNC_DIV(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_clk(cal_clk), .cal_rst_n(cal_rst_n),
        .live_ss(live_ss), .live_tm(live_tm), .live_dt(live_dt),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .bypass(bypass), .flag_clr(flag_clr), .sync_flag(sync_flag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [RD_W-1:0] v, output logic [31:0] n_at);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s;
        #1 v = rd_data; n_at = n;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'd3;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    function automatic bit coherent(input logic [RD_W-1:0] s, input logic [RD_W-1:0] t,
                                    input logic [RD_W-1:0] d);
        return (int'(s) == 3 - int'(t % 4)) && (d == t / 4);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [RD_W-1:0] vs, vt, vd, t_prev;
        logic [31:0] na, nb;
        repeat (8) @(negedge clk);
        rst_n = 1'b1; cal_rst_n = 1'b1;
        #1 check(sync_flag == 1'b0, "R1 flag low after reset", sync_flag, 0);
        rd(2'd3, vs, na);
        check(vs == 0, "R9 unused select reads zero", vs, 0);
        rd(2'd0, vs, na); check(vs == 0, "R1 sub-second zero", vs, 0);
        rd(2'd1, vt, na); check(vt == 0, "R1 time zero", vt, 0);
        rd(2'd2, vd, na); check(vd == 0, "R1 date zero", vd, 0);

        // R3: the flag rises on the first reload.
        idle(60);
        check(sync_flag == 1'b1, "R3 flag set after reload", sync_flag, 1);

        // R4 / R6: a sub-second read freezes the set and drops the flag.
        rd(2'd0, vs, na);
        check(sync_flag == 1'b0, "R6 freeze clears flag", sync_flag, 0);
        idle(50);
        check(sync_flag == 1'b0, "R6 flag stays low while frozen", sync_flag, 0);
        rd(2'd1, vt, nb);
        check(vt <= na && vt + 4 >= na, "R4 time frozen at sub-second read", vt, na);
        rd(2'd2, vd, nb);
        check(coherent(vs, vt, vd), "R2 coherent frozen set", vd, vt / 4);
        t_prev = vt;

        // R5: release brings the deferred and later reloads back.
        idle(40);
        check(sync_flag == 1'b1, "R5 flag set after release", sync_flag, 1);
        rd(2'd0, vs, na); rd(2'd1, vt, nb); rd(2'd2, vd, nb);
        check(vt > t_prev, "R5 reloads resume after release", vt, t_prev + 1);
        check(coherent(vs, vt, vd), "R2 coherent set after release", vd, vt / 4);

        // R2 / R4 sweep over read spacing.
        for (int g = 0; g < 24; g++) begin
            for (int r = 0; r < 4; r++) begin
                idle(g);
                rd(2'd0, vs, na);
                idle(g);
                rd(2'd1, vt, nb);
                idle(g);
                rd(2'd2, vd, nb);
                check(coherent(vs, vt, vd), "R2 coherent set in sweep", vs, 3 - int'(vt % 4));
                check(vt <= na && vt + 4 >= na, "R4 freshness at freeze in sweep", vt, na);
            end
        end

        // R8: bypass shows live values and takes no freeze.
        idle(40);
        bypass = 1'b1;
        rd(2'd0, vs, na);
        check(vs == RD_W'(3 - (na % 4)), "R8 bypass live sub-second", vs, 3 - (na % 4));
        rd(2'd1, vt, na);
        check(vt == RD_W'(na), "R8 bypass live time", vt, na);
        rd(2'd2, vd, na);
        check(vd == RD_W'(na / 4), "R8 bypass live date", vd, na / 4);
        rd(2'd0, vs, na);
        bypass = 1'b0;
        idle(40);
        check(sync_flag == 1'b1, "R8 bypass read left flag set", sync_flag, 1);

        // R4: a time read also freezes; the earlier bypass read did not.
        rd(2'd1, vt, na);
        check(vt <= na && vt + 4 >= na, "R8 no freeze from bypass read", vt, na);
        check(sync_flag == 1'b0, "R4 time read freezes and clears flag", sync_flag, 0);
        idle(40);
        rd(2'd2, vd, nb);
        check(vd == vt / 4, "R4 date matches frozen time", vd, vt / 4);

        // R9: unused select does not release or freeze.
        rd(2'd0, vs, na);
        idle(40);
        rd(2'd3, vd, nb);
        idle(40);
        check(sync_flag == 1'b0, "R9 unused select leaves freeze", sync_flag, 0);
        rd(2'd2, vd, nb);
        idle(40);
        check(sync_flag == 1'b1, "R5 released by date read", sync_flag, 1);

        // R7: a clear write drops the flag, and the next reload sets it again.
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        for (int i = 0; i < 60 && !sync_flag; i++) @(negedge clk);
        check(sync_flag == 1'b1, "R7 flag returns after clear", sync_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check(sync_flag == 1'b0, "R7 clear write drops flag", sync_flag, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule